// File: doc/BRIEF.md
# Flash Query Geometry Probe

This block learns the layout of a parallel NOR flash on its own once `start` is pulsed. It places the flash in query mode and confirms the query signature. It then reads the size exponent, the number of erase regions, and the four geometry bytes of each region. The geometry is decoded into block counts and block byte sizes, which are held in a small register file. The total byte capacity is accumulated one region per cycle. A reset command then returns the flash to array mode, and `done` is raised.

Some devices list their erase regions in a fixed order that ignores where the boot blocks sit. The block reads a boot-location byte from the vendor area, choosing the layout rule by the `mfr_id` input. If that location contradicts the order of the region sizes, the region list is reversed.

All pins are plain control and status. The flash side is a bus with one-cycle strobes, and it carries no back-pressure. A read strobe `fl_re` is high for exactly one cycle, and the flash must present the data on `fl_rdata` in the following cycle. A write strobe `fl_we` carries the address and data in the same cycle.

Top module: `cfi_probe`

## Requirements
- R1: The first bus transaction after an accepted `start` is a write of 0x98 to word address 0x055, and this command is written exactly once per probe.
- R2: If the low byte read at 0x010 is not 0x51 (ASCII 'Q'), the block writes the reset command and finishes with `proto_err`=1, `region_count`=0, `total_bytes`=0, all region slots zero and `size_exp`=0.
- R3: `size_exp` equals the low byte read at 0x027.
- R4: If the region-count byte at 0x02C is larger than MAX_REGIONS, the block writes the reset command and finishes with `proto_err`=1, `region_count`=0, `total_bytes`=0 and all slots zero. A count of 0 is accepted.
- R5: Region i is read from the four bytes at 0x02D+4*i: count low, count high, size low, size high. Its slot holds blocks = {high,low}+1 (17 bits) and bytes = {high,low,8'h00}*DEV_COUNT. Slot i sits at `region_blocks[17*i +: 17]` and `region_bytes[32*i +: 32]`. Unused slots read zero.
- R6: Only bits [7:0] of every read are used; the upper bits of `fl_rdata` have no effect.
- R7: The vendor-area base is the byte at 0x015. When `mfr_id`==0x1F, the boot location is read from base+6: bit 0 set means bottom boot, clear means top boot.
- R8: For any other `mfr_id`, the byte at base+15 decides the boot location: 2 means bottom, 3 means top, and any other value means symmetric.
- R9: With two or more regions, the slot order is reversed in two cases: the boot location is top and slot 0's bytes are smaller than the last slot's, or the boot location is bottom and slot 0's bytes are larger. No other case changes the order.
- R10: On success, `total_bytes` equals the sum over the regions of blocks*bytes, and `proto_err`=0.
- R11: The last bus action of every probe is a write of 0xF0 to 0x555, and `done` rises in the next cycle. While `done` is high the bus stays idle. `done` holds until the next accepted `start`, and a `start` pulse during a probe is ignored.
- R12: A read strobe is never high in two consecutive cycles, and no cycle carries both strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a probe (accepted when idle or done) |
| mfr_id | input | 8 | Manufacturer code choosing the boot-location rule |
| fl_addr | output | ADDR_W | Flash word address |
| fl_wdata | output | DATA_W | Flash write data |
| fl_we | output | 1 | One-cycle write strobe |
| fl_re | output | 1 | One-cycle read strobe |
| fl_rdata | input | DATA_W | Read data, valid the cycle after `fl_re` |
| done | output | 1 | Probe finished, flash back in array mode |
| proto_err | output | 1 | Signature or region count invalid |
| size_exp | output | 8 | Device size is 2**size_exp bytes |
| region_count | output | $clog2(MAX_REGIONS+1) | Number of valid region slots |
| region_blocks | output | 17*MAX_REGIONS | Block count per slot |
| region_bytes | output | 32*MAX_REGIONS | Block size in bytes per slot |
| total_bytes | output | 48 | Sum of blocks*bytes over slots |

## Verification
The assertions assume that the flash answers every read strobe in the following cycle, and that `mfr_id` stays stable for the whole of a probe. They also assume the region count held during an order-swap cycle does not change in the cycle after it. The bench flash model answers each strobe on the next edge and fills the upper read byte with a fixed non-zero pattern. The bench changes `mfr_id` only between probes. It sweeps every region count from 0 to MAX_REGIONS+1 against all five boot-location cases, in both ascending and descending size order, and adds a bad-signature run.

// File: rtl/cfi_probe_pkg.sv
package cfi_probe_pkg;
  localparam logic [7:0] CMD_QUERY   = 8'h98;
  localparam logic [7:0] CMD_ARRAY   = 8'hF0;
  localparam logic [7:0] SIG_BYTE    = 8'h51;
  localparam logic [7:0] MFR_BITFLAG = 8'h1F;
  localparam int OFS_ENTER  = 'h055;
  localparam int OFS_RESET  = 'h555;
  localparam int OFS_SIG    = 'h010;
  localparam int OFS_VPTR   = 'h015;
  localparam int OFS_SIZE   = 'h027;
  localparam int OFS_NREG   = 'h02C;
  localparam int OFS_REG0   = 'h02D;
  localparam int VOFS_FLAG  = 6;
  localparam int VOFS_CODE  = 15;
  localparam int CNT_W      = 17;
  localparam int BSZ_W      = 32;
  localparam int TOT_W      = 48;

  typedef enum logic [1:0] {BOOT_SYM, BOOT_BOTTOM, BOOT_TOP} boot_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ENTER, ST_SIG, ST_SIZE, ST_NREG, ST_REGB,
    ST_VPTR, ST_VBOOT, ST_ORDER, ST_SUM, ST_EXIT, ST_DONE
  } st_e;
endpackage

// File: rtl/cfi_boot_decode.sv
module cfi_boot_decode
  import cfi_probe_pkg::*;
(
  input  logic [7:0] mfr_id,
  input  logic [7:0] code,
  output boot_e      boot
);
  always_comb begin
    if (mfr_id == MFR_BITFLAG) begin
      boot = code[0] ? BOOT_BOTTOM : BOOT_TOP;
    end else begin
      unique case (code)
        8'h02:   boot = BOOT_BOTTOM;
        8'h03:   boot = BOOT_TOP;
        default: boot = BOOT_SYM;
      endcase
    end
  end
endmodule

// File: rtl/cfi_region_file.sv
module cfi_region_file
  import cfi_probe_pkg::*;
#(
  parameter int MAX_REGIONS = 4,
  parameter int DEV_COUNT   = 1,
  localparam int IDX_W = (MAX_REGIONS > 1) ? $clog2(MAX_REGIONS) : 1,
  localparam int N_W   = $clog2(MAX_REGIONS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [15:0]                   raw_cnt,
  input  logic [15:0]                   raw_size,
  input  logic                          rev_en,
  input  logic [N_W-1:0]                n_used,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [CNT_W-1:0]              rd_blocks,
  output logic [BSZ_W-1:0]              rd_bytes,
  output logic [BSZ_W-1:0]              first_bytes,
  output logic [BSZ_W-1:0]              last_bytes,
  output logic [MAX_REGIONS*CNT_W-1:0]  blocks_flat,
  output logic [MAX_REGIONS*BSZ_W-1:0]  bytes_flat
);
  logic [CNT_W-1:0] blk_q [MAX_REGIONS];
  logic [BSZ_W-1:0] bsz_q [MAX_REGIONS];
  logic [CNT_W-1:0] blk_d [MAX_REGIONS];
  logic [BSZ_W-1:0] bsz_d [MAX_REGIONS];
  logic [CNT_W-1:0] dec_blk;
  logic [BSZ_W-1:0] dec_bsz;

  assign dec_blk = {1'b0, raw_cnt} + CNT_W'(1);
  assign dec_bsz = BSZ_W'({raw_size, 8'h00}) * BSZ_W'(DEV_COUNT);

  always_comb begin
    for (int i = 0; i < MAX_REGIONS; i++) begin
      blk_d[i] = blk_q[i];
      bsz_d[i] = bsz_q[i];
      if (clr) begin
        blk_d[i] = '0;
        bsz_d[i] = '0;
      end else if (rev_en && (i < int'(n_used))) begin
        blk_d[i] = blk_q[IDX_W'(int'(n_used) - 1 - i)];
        bsz_d[i] = bsz_q[IDX_W'(int'(n_used) - 1 - i)];
      end else if (wr_en && (int'(wr_idx) == i)) begin
        blk_d[i] = dec_blk;
        bsz_d[i] = dec_bsz;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_REGIONS; i++) begin
        blk_q[i] <= '0;
        bsz_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < MAX_REGIONS; i++) begin
        blk_q[i] <= blk_d[i];
        bsz_q[i] <= bsz_d[i];
      end
    end
  end

  assign rd_blocks   = blk_q[rd_idx];
  assign rd_bytes    = bsz_q[rd_idx];
  assign first_bytes = bsz_q[0];
  assign last_bytes  = bsz_q[IDX_W'(n_used - N_W'(1))];

  for (genvar g = 0; g < MAX_REGIONS; g++) begin : g_flat
    assign blocks_flat[g*CNT_W +: CNT_W] = blk_q[g];
    assign bytes_flat[g*BSZ_W +: BSZ_W]  = bsz_q[g];
  end

  // R9: after an order swap the first slot holds what the last slot held
  assert_reverse_swaps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_en && !clr && n_used >= N_W'(2)) |=> (bsz_q[0] == $past(last_bytes)));

  // R2: a clear empties the first slot
  assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (blk_q[0] == '0 && bsz_q[0] == '0));
endmodule

// File: rtl/cfi_probe.sv
module cfi_probe
  import cfi_probe_pkg::*;
#(
  parameter int MAX_REGIONS = 4,
  parameter int DEV_COUNT   = 1,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  localparam int IDX_W = (MAX_REGIONS > 1) ? $clog2(MAX_REGIONS) : 1,
  localparam int N_W   = $clog2(MAX_REGIONS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [7:0]                    mfr_id,
  output logic [ADDR_W-1:0]             fl_addr,
  output logic [DATA_W-1:0]             fl_wdata,
  output logic                          fl_we,
  output logic                          fl_re,
  input  logic [DATA_W-1:0]             fl_rdata,
  output logic                          done,
  output logic                          proto_err,
  output logic [7:0]                    size_exp,
  output logic [N_W-1:0]                region_count,
  output logic [MAX_REGIONS*CNT_W-1:0]  region_blocks,
  output logic [MAX_REGIONS*BSZ_W-1:0]  region_bytes,
  output logic [TOT_W-1:0]              total_bytes
);
  st_e              st_q;
  logic             ph_q;
  logic [N_W-1:0]   n_q;
  logic [N_W-1:0]   ri_q;
  logic [1:0]       bk_q;
  logic [23:0]      acc_q;
  logic [7:0]       vptr_q, boot_q, size_q;
  logic             err_q, done_q;
  logic [TOT_W-1:0] total_q;

  logic [7:0]       rbyte;
  logic             rd_state, cap, clr, wr_en, rev_en;
  boot_e            boot;
  logic [CNT_W-1:0] rd_blocks;
  logic [BSZ_W-1:0] rd_bytes, first_bytes, last_bytes;

  assign rbyte    = fl_rdata[7:0];
  assign rd_state = (st_q == ST_SIG) || (st_q == ST_SIZE) || (st_q == ST_NREG) ||
                    (st_q == ST_REGB) || (st_q == ST_VPTR) || (st_q == ST_VBOOT);
  assign cap      = rd_state && ph_q;
  assign clr      = ((st_q == ST_IDLE) || (st_q == ST_DONE)) && start;
  assign wr_en    = (st_q == ST_REGB) && ph_q && (bk_q == 2'd3);

  cfi_boot_decode u_boot (.mfr_id(mfr_id), .code(boot_q), .boot(boot));

  assign rev_en = (st_q == ST_ORDER) && (n_q >= N_W'(2)) &&
                  (((boot == BOOT_TOP)    && (first_bytes < last_bytes)) ||
                   ((boot == BOOT_BOTTOM) && (first_bytes > last_bytes)));

  cfi_region_file #(.MAX_REGIONS(MAX_REGIONS), .DEV_COUNT(DEV_COUNT)) u_file (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(wr_en), .wr_idx(IDX_W'(ri_q)),
    .raw_cnt(acc_q[15:0]), .raw_size({rbyte, acc_q[23:16]}),
    .rev_en(rev_en), .n_used(n_q), .rd_idx(IDX_W'(ri_q)),
    .rd_blocks(rd_blocks), .rd_bytes(rd_bytes),
    .first_bytes(first_bytes), .last_bytes(last_bytes),
    .blocks_flat(region_blocks), .bytes_flat(region_bytes));

  // bus drive, decoded from the current state
  always_comb begin
    fl_we    = 1'b0;
    fl_re    = rd_state && !ph_q;
    fl_wdata = '0;
    fl_addr  = '0;
    unique case (st_q)
      ST_ENTER: begin fl_we = 1'b1; fl_addr = ADDR_W'(OFS_ENTER); fl_wdata = DATA_W'(CMD_QUERY); end
      ST_EXIT:  begin fl_we = 1'b1; fl_addr = ADDR_W'(OFS_RESET); fl_wdata = DATA_W'(CMD_ARRAY); end
      ST_SIG:   fl_addr = ADDR_W'(OFS_SIG);
      ST_SIZE:  fl_addr = ADDR_W'(OFS_SIZE);
      ST_NREG:  fl_addr = ADDR_W'(OFS_NREG);
      ST_REGB:  fl_addr = ADDR_W'(OFS_REG0) + ADDR_W'({ri_q, bk_q});
      ST_VPTR:  fl_addr = ADDR_W'(OFS_VPTR);
      ST_VBOOT: fl_addr = ADDR_W'(vptr_q) +
                          ADDR_W'((mfr_id == MFR_BITFLAG) ? VOFS_FLAG : VOFS_CODE);
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; ph_q <= 1'b0; n_q <= '0; ri_q <= '0; bk_q <= '0;
      acc_q <= '0; vptr_q <= '0; boot_q <= '0; size_q <= '0;
      err_q <= 1'b0; done_q <= 1'b0; total_q <= '0;
    end else begin
      if (rd_state) ph_q <= !ph_q;
      unique case (st_q)
        ST_IDLE, ST_DONE: if (start) begin
          st_q <= ST_ENTER; done_q <= 1'b0; err_q <= 1'b0;
          n_q <= '0; size_q <= '0; total_q <= '0; ph_q <= 1'b0;
        end
        ST_ENTER: st_q <= ST_SIG;
        ST_SIG: if (cap) begin
          if (rbyte == SIG_BYTE) st_q <= ST_SIZE;
          else begin err_q <= 1'b1; st_q <= ST_EXIT; end
        end
        ST_SIZE: if (cap) begin size_q <= rbyte; st_q <= ST_NREG; end
        ST_NREG: if (cap) begin
          if (rbyte > 8'(MAX_REGIONS)) begin
            err_q <= 1'b1; st_q <= ST_EXIT;
          end else begin
            n_q <= N_W'(rbyte); ri_q <= '0; bk_q <= '0;
            st_q <= (rbyte == 8'd0) ? ST_VPTR : ST_REGB;
          end
        end
        ST_REGB: if (cap) begin
          acc_q <= {rbyte, acc_q[23:8]};
          bk_q  <= bk_q + 2'd1;
          if (bk_q == 2'd3) begin
            if (ri_q + N_W'(1) == n_q) st_q <= ST_VPTR;
            else ri_q <= ri_q + N_W'(1);
          end
        end
        ST_VPTR:  if (cap) begin vptr_q <= rbyte; st_q <= ST_VBOOT; end
        ST_VBOOT: if (cap) begin boot_q <= rbyte; st_q <= ST_ORDER; end
        ST_ORDER: begin ri_q <= '0; st_q <= ST_SUM; end
        ST_SUM: begin
          if (ri_q == n_q) st_q <= ST_EXIT;
          else begin
            total_q <= total_q + TOT_W'(rd_blocks) * TOT_W'(rd_bytes);
            ri_q    <= ri_q + N_W'(1);
          end
        end
        ST_EXIT: begin st_q <= ST_DONE; done_q <= 1'b1; end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done         = done_q;
  assign proto_err    = err_q;
  assign size_exp     = size_q;
  assign region_count = err_q ? '0 : n_q;
  assign total_bytes  = total_q;

  // R11: done rises only right after the return-to-array write
  assert_done_after_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fl_we && fl_wdata == DATA_W'(CMD_ARRAY) &&
                          fl_addr == ADDR_W'(OFS_RESET)));
  // R11: bus idle while done
  assert_quiet_when_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!fl_we && !fl_re));
  // R12: every read strobe is followed by a capture cycle
  assert_read_spacing_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fl_re |=> !fl_re);
  // R4: never more valid regions than slots
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    region_count <= N_W'(MAX_REGIONS));
  // R2: a failed probe reports nothing
  assert_err_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && proto_err) |-> (region_count == '0 && total_bytes == '0));
endmodule

// File: tb/cfi_probe_test.sv
`timescale 1ns/1ps
module cfi_probe_test;
  localparam int MAXR = 4;
  localparam int DEVS = 2;
  localparam int AW   = 12;
  localparam int DW   = 16;
  localparam int NW   = $clog2(MAXR + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] mfr_id = 8'h01;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata, fl_rdata;
  logic fl_we, fl_re, done, proto_err;
  logic [7:0] size_exp;
  logic [NW-1:0] region_count;
  logic [MAXR*17-1:0] region_blocks;
  logic [MAXR*32-1:0] region_bytes;
  logic [47:0] total_bytes;

  always #2 clk = ~clk;

  cfi_probe #(.MAX_REGIONS(MAXR), .DEV_COUNT(DEVS), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mfr_id(mfr_id),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(fl_rdata), .done(done), .proto_err(proto_err), .size_exp(size_exp),
    .region_count(region_count), .region_blocks(region_blocks),
    .region_bytes(region_bytes), .total_bytes(total_bytes));

  // flash model contents
  logic [7:0]  m_sig, m_size, m_nreg, m_vptr, m_off6, m_offf;
  logic [15:0] m_cnt [8];
  logic [15:0] m_sz  [8];

  function automatic logic [7:0] lk(input logic [AW-1:0] a);
    logic [7:0] r;
    r = 8'h00;
    if (a == 12'h010) r = m_sig;
    else if (a == 12'h027) r = m_size;
    else if (a == 12'h02C) r = m_nreg;
    else if (a == 12'h015) r = m_vptr;
    else if (a == AW'(m_vptr) + 12'd6)  r = m_off6;
    else if (a == AW'(m_vptr) + 12'd15) r = m_offf;
    else begin
      for (int k = 0; k < 8; k++) begin
        if (a == 12'h02D + 12'(4*k))     r = m_cnt[k][7:0];
        if (a == 12'h02D + 12'(4*k + 1)) r = m_cnt[k][15:8];
        if (a == 12'h02D + 12'(4*k + 2)) r = m_sz[k][7:0];
        if (a == 12'h02D + 12'(4*k + 3)) r = m_sz[k][15:8];
      end
    end
    return r;
  endfunction

  // upper read byte carries junk (R6)
  always @(posedge clk) if (fl_re) fl_rdata <= {8'hA5, lk(fl_addr)};

  // bus log
  logic log_clr = 1'b0;
  int nwr, n_enter, clash;
  logic [AW-1:0] first_a, last_a;
  logic [DW-1:0] first_d, last_d;
  always @(posedge clk) begin
    if (log_clr) begin
      nwr <= 0; n_enter <= 0; clash <= 0;
    end else begin
      if (fl_we) begin
        if (nwr == 0) begin first_a <= fl_addr; first_d <= fl_wdata; end
        last_a <= fl_addr; last_d <= fl_wdata;
        nwr <= nwr + 1;
        if (fl_wdata[7:0] == 8'h98) n_enter <= n_enter + 1;
      end
      if (fl_we && fl_re) clash <= clash + 1;
    end
  end

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_case(input int n, input int mode, input bit badsig);
    longint e_blk[MAXR], e_bsz[MAXR], t_blk[8], t_bsz[8];
    longint e_tot;
    bit err, asc, top, bot, rev;
    int wait_c, nw_done;
    logic [7:0] e_size;
    asc = ((n + mode) % 2) == 1;
    m_sig  = badsig ? 8'h50 : 8'h51;
    m_size = 8'h14 + 8'(n);
    m_nreg = 8'(n);
    m_vptr = 8'h60;
    case (mode)
      0: begin mfr_id = 8'h1F; m_off6 = 8'hFF; m_offf = 8'h03; end
      1: begin mfr_id = 8'h1F; m_off6 = 8'hFE; m_offf = 8'h02; end
      2: begin mfr_id = 8'h01; m_off6 = 8'h00; m_offf = 8'h02; end
      3: begin mfr_id = 8'h01; m_off6 = 8'h01; m_offf = 8'h03; end
      default: begin mfr_id = 8'h01; m_off6 = 8'h01; m_offf = 8'h07; end
    endcase
    bot = (mode == 0) || (mode == 2);
    top = (mode == 1) || (mode == 3);
    for (int i = 0; i < 8; i++) begin
      m_cnt[i] = 16'h0003 + 16'(16'h0100 * i) + 16'(mode);
      m_sz[i]  = asc ? 16'((i + 1) * 16'h40) : 16'((n - i) * 16'h40);
      if (mode == 4 && i == n - 1) m_cnt[i] = 16'hFFFF;
      if (n == 1) m_sz[i] = 16'hFFFF;
      t_blk[i] = longint'(m_cnt[i]) + 1;
      t_bsz[i] = longint'({m_sz[i], 8'h00}) * DEVS;
    end
    err = badsig || (n > MAXR);
    e_size = badsig ? 8'h00 : m_size;
    rev = !err && n >= 2 &&
          ((top && t_bsz[0] < t_bsz[n-1]) || (bot && t_bsz[0] > t_bsz[n-1]));
    e_tot = 0;
    for (int i = 0; i < MAXR; i++) begin
      e_blk[i] = 0; e_bsz[i] = 0;
      if (!err && i < n) begin
        e_blk[i] = rev ? t_blk[n-1-i] : t_blk[i];
        e_bsz[i] = rev ? t_bsz[n-1-i] : t_bsz[i];
        e_tot += e_blk[i] * e_bsz[i];
      end
    end

    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1;   // R11: pulse during a probe, ignored
    @(negedge clk); start = 1'b0;
    wait_c = 0;
    while (!done && wait_c < 500) begin @(negedge clk); wait_c++; end
    chk(done == 1'b1, "R11 done raised", done, 1);
    nw_done = nwr;
    repeat (5) @(negedge clk);
    chk(nwr == nw_done && done, "R11 bus idle while done", nwr, nw_done);
    chk(proto_err == err, err ? (badsig ? "R2 error flag" : "R4 error flag") : "R10 no error",
        proto_err, err);
    chk(size_exp == e_size, "R3 size exponent", size_exp, e_size);
    chk(region_count == NW'(err ? 0 : n), "R5 region count", region_count, err ? 0 : n);
    chk(n_enter == 1, "R1 single query entry", n_enter, 1);
    chk(first_a == 12'h055 && first_d[7:0] == 8'h98, "R1 first write", first_a, 12'h055);
    chk(last_a == 12'h555 && last_d[7:0] == 8'hF0, "R11 last write is reset", last_a, 12'h555);
    chk(clash == 0, "R12 strobe clash", clash, 0);
    chk(total_bytes == 48'(e_tot), "R10 total bytes", total_bytes, e_tot);
    for (int i = 0; i < MAXR; i++) begin
      chk(region_blocks[i*17 +: 17] == 17'(e_blk[i]),
          rev ? "R9 reversed blocks" : (mode >= 2 ? "R8 R5 blocks" : "R7 R5 blocks"),
          region_blocks[i*17 +: 17], e_blk[i]);
      chk(region_bytes[i*32 +: 32] == 32'(e_bsz[i]), "R5 R6 block bytes",
          region_bytes[i*32 +: 32], e_bsz[i]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && proto_err == 1'b0, "R11 reset done low", done, 0);
    chk(!fl_we && !fl_re, "R12 reset bus idle", fl_we, 0);
    chk(total_bytes == 48'd0 && region_count == '0, "R10 reset total", total_bytes, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!fl_we && !fl_re, "R1 no bus activity before start", fl_re, 0);
    for (int n = 0; n <= MAXR + 1; n++)
      for (int mode = 0; mode < 5; mode++)
        run_case(n, mode, 1'b0);
    run_case(3, 3, 1'b1);
    run_case(2, 0, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule